// File: doc/BRIEF.md
# Binary-Weighted Multi-Channel LED Modulator

This block dims 24 LEDs from 8-bit brightness values by bit-angle modulation. No channel has its own comparator. A frame is cut into eight slots, and slot k lasts 2^k base time units. During slot k every output shows bit k of its own brightness value, and all outputs switch together. Only eight timing events happen per frame, so one shared slot timer serves every channel. The lit time of a channel over a frame is proportional to its brightness value.

Software writes brightness bytes into a shadow buffer through a simple write port, one channel per address. The shadow buffer is copied into the active buffer in the last clock of each frame, so a frame never mixes old and new bits. The base time unit, counted in clocks, is also taken only at that frame boundary. A one-clock frame-start pulse marks the first clock of every bit-0 slot.

Top module: `bam_led_driver`

## Requirements
- R1: While reset is asserted and after it is released, led_out is all zero. Counting starts in the first clock of slot 0. The first frame uses a base unit of 1 clock and all-zero brightness.
- R2: Slots run in the order 0,1,...,7 and then return to 0. Slot k lasts unit*2^k clocks, so a frame lasts 255*unit clocks.
- R3: Channel c has write address c. During slot k, led_out[c] equals bit k (bit 0 = LSB) of the active brightness of channel c.
- R4: A write lands in the shadow buffer on the clock edge where wr_en is high. The active buffer takes the whole shadow buffer on the edge that ends the last clock of a frame, and is unchanged at every other edge.
- R5: frame_start is high exactly in the first clock of each slot 0 and low in every other clock.
- R6: unit_cfg (9 bits, in clocks) is sampled on the edge that ends a frame and applies to the next whole frame. The value 0 is taken as 1.
- R7: A brightness of 0 holds its output low for the whole frame, and 255 holds it high for the whole frame.
- R8: A write with wr_addr of 24 or more changes no brightness value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for a brightness byte |
| wr_addr | input | 5 | Channel index of the write |
| wr_data | input | 8 | Brightness value |
| unit_cfg | input | 9 | Base time unit in clocks (0 means 1) |
| frame_start | output | 1 | High in the first clock of every slot 0 |
| led_out | output | 24 | LED drive lines, one per channel |

## Verification
The bench sweeps all 256 brightness values across the channels with base units 0, 1, 2 and 3. It compares every output in every clock against slot boundaries it computes itself. A slot timer off by one clock would shift an edge, and a wrong shift of the unit would stretch the wrong slot; both show up as a wrong bit at the boundary clock. The bench writes new values in the middle of a frame and checks that the old pattern runs to the frame end. A design that copied the buffer at once would show a half-new frame. Writes to out-of-range addresses, and the all-dark and all-lit values, catch address decoding that wraps and bit planes selected in the wrong order.

// File: rtl/bam_pkg.sv
package bam_pkg;
    localparam int DEF_CHANNELS = 24;
    localparam int DEF_LEVEL_W  = 8;
    localparam int DEF_UNIT_W   = 9;
    localparam int DEF_TIMER_W  = 16;
    localparam int DEF_UNIT     = 1;
endpackage

// File: rtl/bam_slot_timer.sv
module bam_slot_timer
    import bam_pkg::*;
#(
    parameter int SLOT_N   = DEF_LEVEL_W,
    parameter int UNIT_W   = DEF_UNIT_W,
    parameter int TIMER_W  = DEF_TIMER_W,
    parameter int RST_UNIT = DEF_UNIT,
    localparam int SLOT_W  = $clog2(SLOT_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [UNIT_W-1:0] unit_cfg,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              frame_start,
    output logic              frame_end
);
    typedef struct packed {
        logic [SLOT_W-1:0]  slot;
        logic [TIMER_W-1:0] cnt;
        logic [UNIT_W-1:0]  unit;
    } tmr_t;

    tmr_t               tmr_d, tmr_q;
    logic [TIMER_W-1:0] span;
    logic               slot_end;

    always_comb begin
        span      = TIMER_W'(tmr_q.unit) << tmr_q.slot;
        slot_end  = (tmr_q.cnt == span - TIMER_W'(1));
        frame_end = slot_end && (tmr_q.slot == SLOT_W'(SLOT_N - 1));
        tmr_d     = tmr_q;
        if (slot_end) begin
            tmr_d.cnt  = '0;
            tmr_d.slot = frame_end ? '0 : tmr_q.slot + SLOT_W'(1);
        end else begin
            tmr_d.cnt = tmr_q.cnt + TIMER_W'(1);
        end
        if (frame_end) begin
            tmr_d.unit = (unit_cfg == '0) ? UNIT_W'(1) : unit_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '{slot: '0, cnt: '0, unit: UNIT_W'(RST_UNIT)};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign slot_idx    = tmr_q.slot;
    assign frame_start = (tmr_q.slot == '0) && (tmr_q.cnt == '0);

    // R2: a slot only advances after its final count
    assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tmr_q.slot) |-> $past(slot_end));
    // R2: the last slot wraps to a fresh slot 0
    assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (tmr_q.slot == '0) && (tmr_q.cnt == '0));
    // R6: unit changes only across a frame boundary and is never zero
    assert_unit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tmr_q.unit) |-> $past(frame_end));
    assert_unit_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.unit != '0);
endmodule

// File: rtl/bam_level_store.sv
module bam_level_store
    import bam_pkg::*;
#(
    parameter int CHANNELS = DEF_CHANNELS,
    parameter int LEVEL_W  = DEF_LEVEL_W,
    localparam int ADDR_W  = $clog2(CHANNELS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [LEVEL_W-1:0]          wr_data,
    input  logic                        commit,
    output logic [CHANNELS*LEVEL_W-1:0] levels
);
    typedef logic [LEVEL_W-1:0] level_t;
    typedef struct packed {
        level_t [CHANNELS-1:0] shadow;
        level_t [CHANNELS-1:0] active;
    } store_t;

    store_t store_d, store_q;

    always_comb begin
        store_d = store_q;
        if (commit) begin
            store_d.active = store_q.shadow;
        end
        for (int ch = 0; ch < CHANNELS; ch++) begin
            if (wr_en && (wr_addr == ADDR_W'(ch))) begin
                store_d.shadow[ch] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    assign levels = store_q.active;

    // R4: the active buffer holds between frame boundaries
    assert_active_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(store_q.active));
    // R4: at a boundary the active buffer takes the prior shadow contents
    assert_commit_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> store_q.active == $past(store_q.shadow));
endmodule

// File: rtl/bam_plane_mux.sv
module bam_plane_mux
    import bam_pkg::*;
#(
    parameter int CHANNELS = DEF_CHANNELS,
    parameter int LEVEL_W  = DEF_LEVEL_W,
    localparam int SLOT_W  = $clog2(LEVEL_W)
) (
    input  logic [CHANNELS*LEVEL_W-1:0] levels,
    input  logic [SLOT_W-1:0]           slot_idx,
    output logic [CHANNELS-1:0]         led
);
    for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
        logic [LEVEL_W-1:0] lvl_w;
        assign lvl_w  = levels[g*LEVEL_W +: LEVEL_W];
        assign led[g] = lvl_w[slot_idx];
    end
endmodule

// File: rtl/bam_led_driver.sv
module bam_led_driver
    import bam_pkg::*;
#(
    parameter int CHANNELS = DEF_CHANNELS,
    parameter int LEVEL_W  = DEF_LEVEL_W,
    parameter int UNIT_W   = DEF_UNIT_W,
    parameter int TIMER_W  = DEF_TIMER_W,
    localparam int ADDR_W  = $clog2(CHANNELS),
    localparam int SLOT_W  = $clog2(LEVEL_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [LEVEL_W-1:0]  wr_data,
    input  logic [UNIT_W-1:0]   unit_cfg,
    output logic                frame_start,
    output logic [CHANNELS-1:0] led_out
);
    logic [SLOT_W-1:0]           slot_idx;
    logic                        frame_end;
    logic [CHANNELS*LEVEL_W-1:0] levels;

    bam_slot_timer #(
        .SLOT_N (LEVEL_W),
        .UNIT_W (UNIT_W),
        .TIMER_W(TIMER_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .unit_cfg   (unit_cfg),
        .slot_idx   (slot_idx),
        .frame_start(frame_start),
        .frame_end  (frame_end)
    );

    bam_level_store #(
        .CHANNELS(CHANNELS),
        .LEVEL_W (LEVEL_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .commit (frame_end),
        .levels (levels)
    );

    bam_plane_mux #(
        .CHANNELS(CHANNELS),
        .LEVEL_W (LEVEL_W)
    ) u_mux (
        .levels  (levels),
        .slot_idx(slot_idx),
        .led     (led_out)
    );

    // R5: the frame-start pulse lasts a single clock
    assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
    // R3: outputs move only when the bit plane moves
    assert_led_on_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(led_out) |-> !$stable(slot_idx));
    // R1: outputs are dark while in reset
    assert_reset_dark_R1: assert property (@(posedge clk)
        !rst_n |-> led_out == '0);
endmodule

// File: tb/bam_led_driver_test.sv
module bam_led_driver_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [8:0]  unit_cfg = 9'd2;
    logic        frame_start;
    logic [23:0] led_out;

    int unsigned checks = 0;
    int unsigned fails = 0;
    bit          started = 0;
    bit          done = 0;
    string       tag = "R1";

    int          pos = 0;
    int          um = 1;
    logic [7:0]  act_m [24];
    logic [7:0]  sh_m [24];

    always #10 clk = ~clk;

    bam_led_driver uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .unit_cfg(unit_cfg),
        .frame_start(frame_start), .led_out(led_out)
    );

    initial begin
        for (int c = 0; c < 24; c++) begin
            act_m[c] = 8'h00;
            sh_m[c]  = 8'h00;
        end
    end

    // model advance: follows the requirements, applied at each active edge
    always @(posedge clk) begin
        if (rst_n) begin
            if (pos == 255 * um - 1) begin
                for (int c = 0; c < 24; c++) act_m[c] = sh_m[c];   // R4 copy before write
                um  = (unit_cfg == 0) ? 1 : int'(unit_cfg);         // R6
                pos = 0;
            end else begin
                pos = pos + 1;
            end
            if (wr_en && wr_addr < 5'd24) sh_m[wr_addr] = wr_data;  // R8 ignore
            started = 1;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            int          slot;
            logic [23:0] exp_led;
            slot = 7;
            for (int k = 0; k < 8; k++) begin
                if (pos < um * ((2 << k) - 1)) begin
                    slot = k;
                    break;
                end
            end
            for (int c = 0; c < 24; c++) exp_led[c] = act_m[c][slot];
            checks++;
            if (led_out !== exp_led) begin
                fails++;
                $display("FAIL %s led_out pos %0d slot %0d unit %0d: got %h expected %h",
                         tag, pos, slot, um, led_out, exp_led);
            end
            checks++;
            if (frame_start !== (pos == 0)) begin
                fails++;
                $display("FAIL R5 frame_start pos %0d: got %b expected %b",
                         pos, frame_start, (pos == 0));
            end
        end
    end

    task automatic put(input int addr, input int val);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 5'(addr);
        wr_data = 8'(val);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic next_frames(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!frame_start) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (led_out !== 24'h0) begin
            fails++;
            $display("FAIL R1 reset led_out: got %h expected %h", led_out, 24'h0);
        end
        rst_n = 1'b1;
        // R1: first frame at unit 1 and dark; load values meanwhile
        tag = "R1";
        for (int c = 0; c < 24; c++) put(c, c * 11);
        next_frames(2);

        // R3: sweep all 256 levels, units 0, 1, 2 rotated
        tag = "R3";
        for (int f = 0; f < 11; f++) begin
            unit_cfg = 9'(f % 3);
            for (int c = 0; c < 24; c++) put(c, (f * 24 + c) % 256);
            next_frames(2);
        end

        // R2: slot lengths at unit 3 with single-bit levels
        tag = "R2";
        unit_cfg = 9'd3;
        for (int c = 0; c < 24; c++) put(c, 1 << (c % 8));
        next_frames(3);

        // R4: change mid-frame; old pattern must finish the frame
        tag = "R4";
        unit_cfg = 9'd1;
        for (int c = 0; c < 24; c++) put(c, 8'hA5);
        next_frames(2);
        repeat (100) @(negedge clk);
        for (int c = 0; c < 24; c++) put(c, 8'h5A);
        next_frames(2);

        // R7: extremes
        tag = "R7";
        for (int c = 0; c < 24; c++) put(c, (c % 2) ? 255 : 0);
        next_frames(3);

        // R8: out-of-range writes change nothing
        tag = "R8";
        for (int c = 0; c < 24; c++) put(c, 0);
        next_frames(2);
        for (int a = 24; a < 32; a++) put(a, 255);
        next_frames(3);

        // R6: zero unit taken as one, then unit 2
        tag = "R6";
        unit_cfg = 9'd0;
        for (int c = 0; c < 24; c++) put(c, 255 - c * 7);
        next_frames(2);
        unit_cfg = 9'd2;
        next_frames(2);

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule